// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus that fronts an internal byte array. It oversamples the clock and data lines with the system clock and recognises command boundaries from data-line edges while the clock line is high. It also frames bytes and answers each accepted byte with an acknowledge by pulling the data line low. The device is selected by a fixed four-bit prefix followed by three bits that must equal three strap inputs. Up to eight such slaves can therefore share one bus.

After selection for writing, the master sends a two-byte word address, most significant byte first. It may then send data bytes. Data bytes are collected in a small pending buffer. They reach the array only when a self-timed programming cycle, started by the closing STOP, runs out. A repeated START with a read select after the word address begins a random read from the loaded address. The read can continue sequentially until the master declines to acknowledge. A write-protect input discards written data but leaves reads untouched. While programming runs, the slave acknowledges nothing. The data line is driven only through an open-drain enable.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) begins a new command at any point and restarts byte framing, so a select byte sent after a START that interrupts a byte is decoded normally.
- R2: A rising data line while the clock line is high (STOP) ends the command: the slave releases the data line and ignores clock pulses until the next START.
- R3: The select byte is sent MSB first, and the slave acknowledges it only when its bits 7..4 are 1010 and its bits 3..1 equal strap_i[2:0]. Bit 0 selects the direction: 1 means read and 0 means write. On any mismatch, no acknowledge is given and the rest of the command is ignored.
- R4: For every byte it accepts, the slave holds sda_oe_o high (the line low) through the whole high phase of the ninth clock pulse and releases it after that pulse's falling edge.
- R5: The word address is two bytes, high byte first. Of the 16 bits, only the low 14 form the address, and these are further reduced modulo the array depth.
- R6: Written data bytes go to consecutive addresses starting at the word address and are stored when the programming cycle ends. At most PEND_BYTES data bytes are accepted per command; a further data byte is not acknowledged and is dropped.
- R7: While wp_i is high, data bytes are still acknowledged but change no array content and start no programming cycle; reads are unaffected.
- R8: A STOP after at least one accepted data byte starts a programming cycle of PROG_CYCLES clocks followed by the commit. For its whole length, the slave gives no acknowledge, not even to its own select byte.
- R9: A read returns the byte at the current address MSB first, one bit per clock pulse, with the line changed only while the clock is low. The address advances by one after each byte and wraps from the top of the array to zero.
- R10: When the master does not acknowledge a read byte, the slave leaves the data line released until the next START or STOP.
- R11: sda_oe_o changes only while the sampled clock line is low, except when it is released at a START or STOP.
- R12: After reset, sda_oe_o is low and the slave waits for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND of all drivers) |
| strap_i | input | 3 | Device-select straps compared with select bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | Open-drain enable, high pulls the data line low |

## Verification
A wrong byte-frame count or sequencer phase shows up at the ports within one byte time. The acknowledge lands on the wrong clock pulse, or it is missing on the next select or address byte. A corrupted address pointer or pending buffer is not visible at once. It appears only when the bytes are read back after the programming cycle, so each write is followed by a random or sequential read that compares against a model of the array. A programming timer that stops early or never starts is caught by a select issued right after the STOP. That select must not be acknowledged, and a select issued after the cycle must be.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Sequencer phase: which byte of the command is being framed
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  // Pending-write engine state
  typedef enum logic [1:0] {
    WB_IDLE,
    WB_WAIT,
    WB_COMMIT
  } wb_state_t;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_sync[SYNC_STAGES-1];
      sda_p    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges only count while the clock stayed high across both samples
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/eep_write_buffer.sv
module eep_write_buffer
  import eep_pkg::*;
#(
  parameter int PEND_BYTES  = 8,
  parameter int AW          = 11,
  parameter int PROG_CYCLES = 5000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          base_ld,
  input  logic [AW-1:0] base_in,
  input  logic          go,
  output logic          full,
  output logic          any,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);

  localparam int CW = $clog2(PEND_BYTES + 1);
  localparam int IW = $clog2(PEND_BYTES);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [7:0]    data_q [PEND_BYTES];
  logic [CW-1:0] cnt_q, idx_q;
  logic [AW-1:0] base_q;
  logic [TW-1:0] tmr_q;
  wb_state_t     st_q;

  assign full = (cnt_q == CW'(PEND_BYTES));
  assign any  = (cnt_q != '0);
  assign busy = (st_q != WB_IDLE);

  // byte storage, no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (st_q == WB_IDLE && push && !full) data_q[cnt_q[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= WB_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      base_q    <= '0;
      tmr_q     <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st_q)
        WB_IDLE: begin
          if (clr) cnt_q <= '0;
          else if (push && !full) cnt_q <= cnt_q + 1'b1;
          if (base_ld) base_q <= base_in;
          if (go && any) begin
            st_q  <= WB_WAIT;
            tmr_q <= TW'(PROG_CYCLES - 1);
          end
        end
        WB_WAIT: begin
          if (tmr_q == '0) begin
            st_q  <= WB_COMMIT;
            idx_q <= '0;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        WB_COMMIT: begin
          mem_we    <= 1'b1;
          mem_waddr <= base_q + AW'(idx_q);
          mem_wdata <= data_q[idx_q[IW-1:0]];
          idx_q     <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) begin
            st_q  <= WB_IDLE;
            cnt_q <= '0;
          end
        end
        default: st_q <= WB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eep_protocol.sv
module eep_protocol
  import eep_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [2:0]    strap,
  input  logic          wp,
  input  logic          busy,
  input  logic          buf_full,
  input  logic          buf_any,
  input  logic [7:0]    rdata,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          push,
  output logic [7:0]    push_data,
  output logic          base_ld,
  output logic [AW-1:0] base_addr,
  output logic          clr,
  output logic          go,
  output phase_t        phase
);

  logic [3:0] cnt_q;
  logic [7:0] shreg, txreg;
  logic [5:0] hi_q;
  logic       mack_n;
  phase_t     nxt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      nxt_q     <= PH_IDLE;
      cnt_q     <= '0;
      shreg     <= '0;
      txreg     <= '0;
      hi_q      <= '0;
      mack_n    <= 1'b1;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      push      <= 1'b0;
      push_data <= '0;
      base_ld   <= 1'b0;
      base_addr <= '0;
      clr       <= 1'b0;
      go        <= 1'b0;
    end else begin
      push    <= 1'b0;
      base_ld <= 1'b0;
      clr     <= 1'b0;
      go      <= 1'b0;
      if (start_det) begin
        phase  <= PH_DEV;
        cnt_q  <= '0;
        sda_oe <= 1'b0;
        clr    <= ~busy;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        go     <= buf_any & ~busy;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt_q < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (cnt_q == 4'd9) begin
            mack_n <= sda_s;
          end
        end
        if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            cnt_q <= 4'd9;
            case (phase)
              PH_RDAT: begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
              end
              PH_DEV: begin
                if (shreg[7:4] == SEL_PREFIX && shreg[3:1] == strap && !busy) begin
                  sda_oe <= 1'b1;
                  nxt_q  <= shreg[0] ? PH_RDAT : PH_AHI;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_AHI: begin
                hi_q   <= shreg[5:0];
                sda_oe <= 1'b1;
                nxt_q  <= PH_ALO;
              end
              PH_ALO: begin
                ptr       <= AW'({hi_q, shreg});
                base_addr <= AW'({hi_q, shreg});
                base_ld   <= 1'b1;
                sda_oe    <= 1'b1;
                nxt_q     <= PH_WDAT;
              end
              PH_WDAT: begin
                if (wp || !buf_full) begin
                  push      <= ~wp;
                  push_data <= shreg;
                  sda_oe    <= 1'b1;
                  ptr       <= ptr + 1'b1;
                  nxt_q     <= PH_WDAT;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end else if (cnt_q == 4'd9) begin
            cnt_q <= '0;
            if (phase == PH_RDAT && mack_n) begin
              phase <= PH_IDLE;
            end else if (phase == PH_RDAT || nxt_q == PH_RDAT) begin
              phase  <= PH_RDAT;
              sda_oe <= ~rdata[7];
              txreg  <= {rdata[6:0], 1'b0};
            end else begin
              phase  <= nxt_q;
              sda_oe <= 1'b0;
            end
          end else if (phase == PH_RDAT && cnt_q != '0) begin
            sda_oe <= ~txreg[7];
            txreg  <= {txreg[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int MEM_DEPTH   = 2048,
  parameter int PEND_BYTES  = 8,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  localparam int AW = $clog2(MEM_DEPTH);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          busy, buf_full, buf_any, push, base_ld, clr, go;
  logic [7:0]    push_data, rdata, mem_wdata;
  logic [AW-1:0] ptr, base_addr, mem_waddr;
  logic          mem_we;
  phase_t        phase;

  eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_protocol #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap(strap_i), .wp(wp_i), .busy(busy), .buf_full(buf_full),
    .buf_any(buf_any), .rdata(rdata), .sda_oe(sda_oe_o), .ptr(ptr),
    .push(push), .push_data(push_data), .base_ld(base_ld),
    .base_addr(base_addr), .clr(clr), .go(go), .phase(phase)
  );

  eep_write_buffer #(.PEND_BYTES(PEND_BYTES), .AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_wbuf (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .push_data(push_data),
    .base_ld(base_ld), .base_in(base_addr), .go(go), .full(buf_full),
    .any(buf_any), .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  eep_mem_array #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata)
  );

endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   scl_s,
  input logic   start_det,
  input logic   stop_det,
  input logic   sda_oe,
  input logic   busy,
  input logic   wp,
  input logic   push,
  input phase_t phase
);

  // R8: silent for the whole programming cycle
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R11: drive changes only follow a low clock, apart from START/STOP release
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  // R1: a START always reopens select-byte framing
  p_start_dev_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_DEV));

  // R2: a STOP leaves the slave idle with the line released
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (phase == PH_IDLE && !sda_oe));

  // R7: nothing enters the pending buffer while protected
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> !$past(wp));

endmodule

bind serial_eeprom_slave eep_checker u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe_o), .busy(busy), .wp(wp_i),
  .push(push), .phase(phase)
);

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;

  localparam int DEPTH = 256;
  localparam int PROG  = 200;
  localparam int PEND  = 4;
  localparam int H     = 8;

  // vector: {word address[13:0], data[7:0]}
  localparam logic [21:0] VEC [6] = '{
    {14'h3F05, 8'hA5}, {14'h0000, 8'h3C}, {14'h00FF, 8'hC3},
    {14'h000E, 8'h77}, {14'h0080, 8'h01}, {14'h1234, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic done = 1'b0;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;

  serial_eeprom_slave #(.MEM_DEPTH(DEPTH), .PEND_BYTES(PEND), .PROG_CYCLES(PROG)) i_serial_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(2);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2);
    ack = (sda_line == 1'b0);
    hw(H/2); scl_m = 1'b0; hw(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); scl_m = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl_m = 1'b0; hw(2);
    end
    sda_m = ~mack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(2); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [13:0] a);
    logic ak;
    do_start();
    send_byte({4'b1010, strap, 1'b0}, ak); chk("R3 select write", ak, 1);
    send_byte({2'b00, a[13:8]}, ak);       chk("R5 addr high ack", ak, 1);
    send_byte(a[7:0], ak);                 chk("R5 addr low ack", ak, 1);
  endtask

  task automatic read_seq(input logic [13:0] a, input int n);
    logic ak;
    set_ptr(a);
    do_start();
    send_byte({4'b1010, strap, 1'b1}, ak); chk("R9 select read", ak, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
  endtask

  task automatic write_seq(input logic [13:0] a, input int n, input int nacc);
    logic ak;
    set_ptr(a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      chk("R6 data ack", ak, (i < nacc) ? 1 : 0);
    end
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic bad;
    hw(5); rst = 1'b0; hw(4);
    chk("R12 released after reset", sda_oe, 0);

    // table-driven single-byte write then random read
    for (int v = 0; v < 6; v++) begin
      logic [13:0] a;
      a = VEC[v][21:8];
      wbuf[0] = VEC[v][7:0];
      write_seq(a, 1, 1);
      do_start();
      send_byte({4'b1010, strap, 1'b0}, ak); chk("R8 no ack while programming", ak, 0);
      do_stop();
      hw(PROG + PEND + 40);
      model[int'(a) % DEPTH] = VEC[v][7:0];
      read_seq(a, 1);
      do_stop();
      chk("R9 random read data", rbuf[0], model[int'(a) % DEPTH]);
    end

    // R5: upper address bits dropped, 0x3F05 aliased to 0x0005
    read_seq(14'h0005, 1); do_stop();
    chk("R5 truncated address", rbuf[0], 8'hA5);

    // R3: strap mismatch and wrong prefix both ignored
    do_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ak); chk("R3 strap mismatch", ak, 0);
    do_stop();
    do_start();
    send_byte({4'b1011, strap, 1'b0}, ak); chk("R3 prefix mismatch", ak, 0);
    do_stop();

    // R4: acknowledge released after ninth pulse
    do_start();
    send_byte({4'b1010, strap, 1'b0}, ak); chk("R4 ack given", ak, 1);
    hw(6);
    chk("R4 released after ack", sda_oe, 0);
    do_stop();
    chk("R2 released after stop", sda_oe, 0);

    // R1: START interrupting a byte restarts framing
    do_start();
    send_bits(8'hA0, 3);
    do_start();
    send_byte({4'b1010, strap, 1'b0}, ak); chk("R1 select after restart", ak, 1);
    do_stop();

    // R7: protected write acked, no programming, content unchanged
    wp = 1'b1;
    set_ptr(14'h0000);
    send_byte(8'hFF, ak); chk("R7 protected data ack", ak, 1);
    do_stop();
    do_start();
    send_byte({4'b1010, strap, 1'b0}, ak); chk("R7 no programming cycle", ak, 1);
    do_stop();
    read_seq(14'h0000, 1); do_stop();
    chk("R7 read while protected", rbuf[0], model[0]);
    wp = 1'b0;

    // R9: multi-byte write and sequential read across the top of the array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_seq(14'h00FE, 4, 4);
    hw(PROG + PEND + 40);
    for (int i = 0; i < 4; i++) model[(254 + i) % DEPTH] = wbuf[i];
    read_seq(14'h00FE, 4); do_stop();
    for (int i = 0; i < 4; i++)
      chk("R9 sequential wrap read", rbuf[i], model[(254 + i) % DEPTH]);

    // R6: byte beyond pending capacity refused and dropped
    for (int i = 0; i < 5; i++) wbuf[i] = 8'h80 + 8'(i);
    write_seq(14'h000A, 5, PEND);
    hw(PROG + PEND + 40);
    for (int i = 0; i < PEND; i++) model[10 + i] = wbuf[i];
    read_seq(14'h000A, 5);
    // R10: after the master NACK the line stays released
    bad = 1'b0;
    for (int i = 0; i < 9; i++) begin
      hw(H); scl_m = 1'b1; hw(H/2);
      if (sda_line !== 1'b1) bad = 1'b1;
      hw(H/2); scl_m = 1'b0; hw(2);
    end
    chk("R10 released after master nack", bad, 0);
    do_stop();
    for (int i = 0; i < 5; i++)
      chk("R6 capacity limit contents", rbuf[i], model[10 + i]);

    chk("R12 idle at end", sda_oe, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule